// File: doc/BRIEF.md
# Split-Pool Descriptor Slot Allocator

This block hands out fixed-size descriptor slots from a small on-chip pool. A bitmap holds one bit per slot, set while the slot is in use. The pool is divided into two fixed halves. Receive allocations draw from the lower half and transmit allocations draw from the upper half, so one direction can never starve the other. Each allocation takes the lowest free slot in its half and returns both the slot index and the slot's byte address. When the half is full, the allocation returns a failure instead.

A free port releases a slot by its index. An allocate and a free may arrive in the same cycle. In that case the free is applied first, so the slot just released can be handed out again at once. A live count of used slots and a flag showing that a transmit slot is free are always present on the outputs. Slot geometry comes from parameters: the descriptor size is rounded up to the alignment to give the slot size, and the pool size divided by the slot size gives the slot count.

Top module: `slot_alloc_top`

## Requirements
- R1: The slot size is DESC_BYTES rounded up to a multiple of ALIGN_BYTES, and the slot count is POOL_BYTES divided by the slot size. The defaults give 16 slots of 32 bytes.
- R2: An allocation with `alloc_is_tx`=0 (receive) only returns indices 0 to N/2-1. An allocation with `alloc_is_tx`=1 (transmit) only returns indices N/2 to N-1.
- R3: A successful allocation returns the lowest-indexed free slot in its half.
- R4: When its half has no free slot, an allocation returns `rsp_ok`=0 and leaves both the bitmap and `used_count` unchanged.
- R5: A successful allocation marks the slot used and raises `used_count` by one. A valid free marks the slot free and lowers `used_count` by one.
- R6: On success, `rsp_addr` equals BASE_ADDR plus `rsp_idx` times the slot size.
- R7: `tx_avail` is high exactly when at least one slot in the upper half is free, and it follows the bitmap as updated at the most recent clock edge.
- R8: When an allocate and a free arrive in the same cycle, the free is applied first, and the freed slot can be returned by that same allocation.
- R9: Freeing a slot that is already free leaves `used_count` and the bitmap unchanged and raises `free_err` for exactly one cycle.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `alloc_valid` high, and low otherwise.
- R11: After reset, every slot is free, `used_count` is 0, `rsp_valid` and `free_err` are low, and `tx_avail` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_is_tx | input | 1 | 1 = transmit half, 0 = receive half |
| free_valid | input | 1 | Free request this cycle |
| free_idx | input | IDX_W | Index of the slot to release |
| rsp_valid | output | 1 | Allocation response valid |
| rsp_ok | output | 1 | Allocation succeeded |
| rsp_idx | output | IDX_W | Index of the allocated slot |
| rsp_addr | output | ADDR_W | Byte address of the allocated slot |
| free_err | output | 1 | One-cycle pulse: the freed slot was not in use |
| tx_avail | output | 1 | At least one transmit slot is free |
| used_count | output | CNT_W | Number of slots in use |

## Verification
The assertions assume that `free_idx` always names a slot inside the pool and that the inputs are settled at every rising edge. The bench drives all inputs on the falling edge and only uses indices from 0 to 15, so both conditions always hold. Beyond that, no restriction is placed on the inputs. A double free and a free issued together with an allocate are legal stimulus, and the bench applies both on purpose.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  function automatic int round_up(input int value, input int align);
    return ((value + align - 1) / align) * align;
  endfunction

  function automatic int max1(input int v);
    return (v < 1) ? 1 : v;
  endfunction
endpackage

// File: rtl/slot_first_free.sv
module slot_first_free #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/slot_bitmap.sv
module slot_bitmap #(
  parameter int N  = 16,
  parameter int IW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  bits,
  output logic [CW-1:0] used
);
  logic [N-1:0]  bits_q, bits_d;
  logic [CW-1:0] used_q, used_d;
  logic          upd_en;

  assign upd_en = set_en | clr_en;

  always_comb begin
    bits_d = bits_q;
    if (clr_en) bits_d[clr_idx] = 1'b0;
    if (set_en) bits_d[set_idx] = 1'b1;
    used_d = used_q - CW'(clr_en) + CW'(set_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      used_q <= '0;
    end else if (upd_en) begin
      bits_q <= bits_d;
      used_q <= used_d;
    end
  end

  assign bits = bits_q;
  assign used = used_q;

  // R5: the counter always matches the population of the bitmap
  a_r5_used_matches: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_q) == $countones(bits_q));

  // R3: a slot being set was free, or is the one freed in the same cycle
  a_r3_set_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (!bits_q[set_idx] || (clr_en && clr_idx == set_idx)));

  // R9: a failed free leaves the map untouched
  a_r9_clear_only_used: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> bits_q[clr_idx]);
endmodule

// File: rtl/slot_alloc_top.sv
module slot_alloc_top
  import slot_alloc_pkg::*;
#(
  parameter int          POOL_BYTES  = 512,
  parameter int          DESC_BYTES  = 28,
  parameter int          ALIGN_BYTES = 16,
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] BASE_ADDR   = 32'h0000_8000,
  localparam int SLOT_BYTES = round_up(DESC_BYTES, ALIGN_BYTES),
  localparam int N          = POOL_BYTES / SLOT_BYTES,
  localparam int IDX_W      = max1($clog2(N)),
  localparam int CNT_W      = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_is_tx,
  input  logic              free_valid,
  input  logic [IDX_W-1:0]  free_idx,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              free_err,
  output logic              tx_avail,
  output logic [CNT_W-1:0]  used_count
);
  localparam int HALF = N / 2;
  localparam int HW   = max1($clog2(HALF));
  localparam int PW   = 1 << IDX_W;

  logic [N-1:0]     bits;
  logic [PW-1:0]    bits_pad;
  logic [N-1:0]     clr_mask, masked;
  logic             free_hit, free_miss;
  logic [1:0]       half_found;
  logic [HW-1:0]    half_idx [2];
  logic             sel_found, alloc_ok;
  logic [IDX_W-1:0] alloc_idx;
  logic [ADDR_W-1:0] alloc_addr;

  // response registers
  logic              rsp_valid_q, rsp_ok_q, free_err_q;
  logic [IDX_W-1:0]  rsp_idx_q;
  logic [ADDR_W-1:0] rsp_addr_q;

  assign bits_pad  = PW'(bits);
  assign free_hit  = free_valid &&  bits_pad[free_idx];
  assign free_miss = free_valid && !bits_pad[free_idx];

  // the free is applied before the search
  assign clr_mask = free_hit ? (N'(1) << free_idx) : '0;
  assign masked   = bits & ~clr_mask;

  for (genvar h = 0; h < 2; h++) begin : g_half
    slot_first_free #(.W(HALF), .IW(HW)) u_ff (
      .busy  (masked[h*HALF +: HALF]),
      .found (half_found[h]),
      .idx   (half_idx[h])
    );
  end

  always_comb begin
    sel_found  = alloc_is_tx ? half_found[1] : half_found[0];
    alloc_ok   = alloc_valid && sel_found;
    alloc_idx  = alloc_is_tx ? (IDX_W'(half_idx[1]) + IDX_W'(HALF))
                             : IDX_W'(half_idx[0]);
    alloc_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(alloc_idx) * ADDR_W'(SLOT_BYTES);
  end

  slot_bitmap #(.N(N), .IW(IDX_W), .CW(CNT_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (alloc_ok),
    .set_idx (alloc_idx),
    .clr_en  (free_hit),
    .clr_idx (free_idx),
    .bits    (bits),
    .used    (used_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_ok_q    <= 1'b0;
      free_err_q  <= 1'b0;
    end else begin
      rsp_valid_q <= alloc_valid;
      rsp_ok_q    <= alloc_ok;
      free_err_q  <= free_miss;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_idx_q  <= '0;
      rsp_addr_q <= '0;
    end else if (alloc_ok) begin
      rsp_idx_q  <= alloc_idx;
      rsp_addr_q <= alloc_addr;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ok    = rsp_ok_q;
  assign rsp_idx   = rsp_idx_q;
  assign rsp_addr  = rsp_addr_q;
  assign free_err  = free_err_q;
  assign tx_avail  = ~&bits[N-1:HALF];

  // R10: response timing
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_valid |=> !rsp_valid);

  // R2: each direction stays inside its half
  a_r2_tx_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_is_tx) |=> (!rsp_ok || int'(rsp_idx) >= HALF));
  a_r2_rx_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_is_tx) |=> (!rsp_ok || int'(rsp_idx) < HALF));

  // R9: a free of an unused slot pulses the error
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && !bits_pad[free_idx]) |=> free_err);

  // R4: a failed allocation with no free changes no count
  a_r4_fail_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !sel_found && !free_valid) |=> $stable(used_count));
endmodule

// File: tb/slot_alloc_top_test.sv
module slot_alloc_top_test;
  localparam int N = 16;
  localparam int HALF = 8;
  localparam int SLOT = 32;
  localparam logic [31:0] BASE = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, alloc_is_tx, free_valid;
  logic [3:0]  free_idx;
  logic        rsp_valid, rsp_ok, free_err, tx_avail;
  logic [3:0]  rsp_idx;
  logic [31:0] rsp_addr;
  logic [4:0]  used_count;

  int checks = 0;
  int errors = 0;
  bit model [N];
  int model_used = 0;

  slot_alloc_top uut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_is_tx(alloc_is_tx),
    .free_valid(free_valid), .free_idx(free_idx), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_idx(rsp_idx), .rsp_addr(rsp_addr), .free_err(free_err),
    .tx_avail(tx_avail), .used_count(used_count)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model_tx_avail();
    for (int i = HALF; i < N; i++) if (!model[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_alloc(input bit tx, input string tag);
    int lo = tx ? HALF : 0;
    int exp_idx = -1;
    for (int i = lo; i < lo + HALF; i++) if (!model[i] && exp_idx < 0) exp_idx = i;
    @(negedge clk);
    alloc_valid = 1'b1; alloc_is_tx = tx;
    @(posedge clk); #1;
    alloc_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " R10 rsp_valid"}, rsp_valid, 1);
    check(rsp_ok == (exp_idx >= 0), {tag, " R4 rsp_ok"}, rsp_ok, exp_idx >= 0);
    if (exp_idx >= 0) begin
      model[exp_idx] = 1'b1; model_used++;
      check(int'(rsp_idx) == exp_idx, {tag, " R3 rsp_idx"}, rsp_idx, exp_idx);
      check(rsp_addr == BASE + 32'(exp_idx * SLOT), {tag, " R6 rsp_addr"},
            rsp_addr, BASE + 32'(exp_idx * SLOT));
    end
    check(int'(used_count) == model_used, {tag, " R5 used_count"}, used_count, model_used);
    check(tx_avail == model_tx_avail(), {tag, " R7 tx_avail"}, tx_avail, model_tx_avail());
  endtask

  task automatic do_free(input int idx, input string tag);
    bit exp_err = !model[idx];
    @(negedge clk);
    free_valid = 1'b1; free_idx = 4'(idx);
    @(posedge clk); #1;
    free_valid = 1'b0;
    if (!exp_err) begin model[idx] = 1'b0; model_used--; end
    check(free_err == exp_err, {tag, " R9 free_err"}, free_err, exp_err);
    check(int'(used_count) == model_used, {tag, " R5 used after free"}, used_count, model_used);
    check(tx_avail == model_tx_avail(), {tag, " R7 tx_avail"}, tx_avail, model_tx_avail());
    @(posedge clk); #1;
    check(free_err == 1'b0, {tag, " R9 err one cycle"}, free_err, 0);
  endtask

  task automatic t_reset();
    check(used_count == 0, "R11 used after reset", used_count, 0);
    check(rsp_valid == 0, "R11 rsp_valid after reset", rsp_valid, 0);
    check(free_err == 0, "R11 free_err after reset", free_err, 0);
    check(tx_avail == 1, "R11 tx_avail after reset", tx_avail, 1);
  endtask

  task automatic t_rx_fill();
    for (int k = 0; k < HALF; k++) do_alloc(1'b0, "rx_fill");
    do_alloc(1'b0, "rx_exhaust R4");
    check(tx_avail == 1, "R7 rx full does not touch tx", tx_avail, 1);
    @(posedge clk); #1;
    check(rsp_valid == 0, "R10 idle cycle no response", rsp_valid, 0);
  endtask

  task automatic t_tx_fill();
    do_alloc(1'b1, "tx_first R1");
    check(rsp_idx == 4'd8 && rsp_addr == BASE + 32'd256, "R1 tx base slot geometry",
          rsp_addr, BASE + 32'd256);
    for (int k = 1; k < HALF; k++) do_alloc(1'b1, "tx_fill");
    check(tx_avail == 0, "R7 tx full", tx_avail, 0);
    do_alloc(1'b1, "tx_exhaust R4");
    do_alloc(1'b0, "rx_still_full R2");
  endtask

  task automatic t_free_reuse();
    do_free(5, "free5");
    do_free(3, "free3");
    do_alloc(1'b0, "reuse_lowest R3");
    do_free(12, "free12 R7");
    do_alloc(1'b1, "tx_reuse R2");
  endtask

  task automatic t_double_free();
    do_free(5, "free5_again");
    do_free(5, "double_free R9");
    do_alloc(1'b0, "after_double R4");
  endtask

  task automatic t_simultaneous();
    // rx half is full; free 2 and allocate rx in the same cycle
    @(negedge clk);
    free_valid = 1'b1; free_idx = 4'd2;
    alloc_valid = 1'b1; alloc_is_tx = 1'b0;
    @(posedge clk); #1;
    free_valid = 1'b0; alloc_valid = 1'b0;
    check(rsp_ok == 1, "R8 same-cycle alloc succeeds", rsp_ok, 1);
    check(rsp_idx == 4'd2, "R8 freed slot reused", rsp_idx, 2);
    check(free_err == 0, "R8 no free error", free_err, 0);
    check(int'(used_count) == model_used, "R8 used unchanged", used_count, model_used);
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = 1'b0;
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_is_tx = 1'b0;
    free_valid = 1'b0; free_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_rx_fill();
    t_tx_fill();
    t_free_reuse();
    t_double_free();
    t_simultaneous();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule